// File: doc/BRIEF.md
# Next Program Counter Unit

This unit holds the program counter of a single-cycle processor and picks its next value on every rising clock edge. It adds four to the current address to get the sequential successor. It also forms two other candidates from the instruction word. The first is a relative branch destination: the low 16 instruction bits are a signed word offset, scaled by four and added to the sequential address. The second is an absolute jump destination: the low 26 instruction bits supply a word index, placed inside the 256 MiB region of the sequential address.

The decoder supplies a branch flag and a jump flag, and the ALU supplies its zero result. A jump overrides everything else. A branch is followed only when the ALU reports zero; otherwise execution falls through. The current address and its sequential successor are both outputs, so fetch and link logic can use them.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0 and stays 0 across clock edges, whatever the other inputs; the reset takes effect without waiting for a clock edge.
- R2: `pc_plus4` always equals `pc + 4` in the same cycle, truncated to 32 bits.
- R3: With `is_jump` and `is_branch` both low, the next `pc` after a rising edge is the previous `pc + 4`.
- R4: With `is_branch` high, `alu_zero` high and `is_jump` low, the next `pc` is `pc + 4` plus the value of `instr[15:0]`, sign-extended and multiplied by 4.
- R5: With `is_branch` high, `alu_zero` low and `is_jump` low, the next `pc` is `pc + 4`.
- R6: `alu_zero` has no effect when `is_branch` and `is_jump` are low: the next `pc` is `pc + 4`.
- R7: With `is_jump` high, the next `pc` is formed as follows: bits 31..28 are copied from `pc + 4`, bits 27..2 come from `instr[25:0]`, and bits 1..0 are zero.
- R8: `is_jump` has priority over a taken branch: with all three control inputs high, the jump target of R7 is loaded.
- R9: Address arithmetic wraps modulo 2^32. For example, `pc` = 0xFFFFFFFC gives `pc_plus4` = 0 and a next sequential `pc` of 0.
- R10: Branch offsets are signed two's complement. Bit 15 of `instr` set means a backward branch, down to -0x20000 bytes for offset 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `pc` is loaded on the rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously by the system; clears `pc` |
| instr | input | 32 | Current instruction word; bits 15..0 hold the branch offset, bits 25..0 hold the jump index |
| is_branch | input | 1 | Decoder flag marking a conditional branch |
| is_jump | input | 1 | Decoder flag marking an unconditional jump |
| alu_zero | input | 1 | ALU zero result, used as the branch condition |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential successor of `pc` |

## Verification
`pc_plus4` is combinational, so it is due in the same cycle as `pc`. A new `pc` is due one rising edge after its control inputs and instruction have been applied. The bench applies each vector at a falling edge. It then compares `pc` and `pc_plus4` at the following falling edge, half a cycle after the register has loaded, so each comparison covers exactly one register stage. Reset is checked a moment after `rst_n` falls between edges, and again after a clock edge while reset is held. This confirms the clear is asynchronous and dominates the other inputs.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // Which candidate address feeds the program counter register.
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_sel_e;

  // Byte shift that turns a word count into a byte address offset.
  localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_next_o
);
  localparam logic [AW-1:0] STEP = AW'(1) << npc_pkg::WORD_SHIFT;

  // Sum is truncated to AW bits, so it wraps modulo 2^AW.
  always_comb begin
    addr_next_o = addr_i + STEP;
  end

endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFS_W = 16
) (
  input  logic [AW-1:0]    base_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [AW-1:0]    tgt_o
);
  localparam int unsigned SH    = npc_pkg::WORD_SHIFT;
  localparam int unsigned EXT_W = AW - OFS_W - SH;

  logic [AW-1:0] ofs_bytes;

  always_comb begin
    ofs_bytes = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i, {SH{1'b0}}};
    tgt_o     = base_i + ofs_bytes;
  end

endmodule

// File: rtl/npc_jump_tgt.sv
module npc_jump_tgt #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 26
) (
  input  logic [AW-1:0]    seq_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    tgt_o
);
  localparam int unsigned SH   = npc_pkg::WORD_SHIFT;
  localparam int unsigned HI_W = AW - IDX_W - SH;

  generate
    if (HI_W > 0) begin : g_region
      logic unused_seq_lo;
      assign unused_seq_lo = ^seq_i[AW-HI_W-1:0];
      assign tgt_o = {seq_i[AW-1 -: HI_W], idx_i, {SH{1'b0}}};
    end else begin : g_flat
      logic unused_seq;
      assign unused_seq = ^seq_i;
      assign tgt_o = {idx_i, {SH{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IW    = 32,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned IDX_W = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] instr,
  input  logic          is_branch,
  input  logic          is_jump,
  input  logic          alu_zero,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] pc_plus4
);
  import npc_pkg::*;

  localparam int unsigned HI_W = AW - IDX_W - WORD_SHIFT;

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] br_addr;
  logic [AW-1:0] jmp_addr;
  npc_sel_e      sel;

  logic unused_opcode;
  assign unused_opcode = ^instr[IW-1:IDX_W];

  npc_incr #(.AW(AW)) i_incr (
    .addr_i      (pc_q),
    .addr_next_o (seq_addr)
  );

  npc_branch_tgt #(.AW(AW), .OFS_W(OFS_W)) i_branch_tgt (
    .base_i (seq_addr),
    .ofs_i  (instr[OFS_W-1:0]),
    .tgt_o  (br_addr)
  );

  npc_jump_tgt #(.AW(AW), .IDX_W(IDX_W)) i_jump_tgt (
    .seq_i (seq_addr),
    .idx_i (instr[IDX_W-1:0]),
    .tgt_o (jmp_addr)
  );

  // Next-state: jump wins, then a taken branch, else fall through.
  always_comb begin
    if (is_jump) begin
      sel = NPC_JUMP;
    end else if (is_branch && alu_zero) begin
      sel = NPC_BRANCH;
    end else begin
      sel = NPC_SEQ;
    end
    unique case (sel)
      NPC_JUMP:   pc_d = jmp_addr;
      NPC_BRANCH: pc_d = br_addr;
      default:    pc_d = seq_addr;
    endcase
  end

  // Register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc       = pc_q;
  assign pc_plus4 = seq_addr;

  // R1: held at zero through reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> pc == '0);

  // R3, R6: fall-through advances by one word
  assert_fall_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_jump && !(is_branch && alu_zero)) |=> pc == $past(pc_plus4));

  // R4: taken branch loads the relative target
  assert_branch_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && alu_zero && !is_jump) |=> pc == $past(br_addr));

  // R5: untaken branch falls through
  assert_branch_untaken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !alu_zero && !is_jump) |=> pc == $past(pc) + AW'(4));

  // R7, R8: jump keeps region bits, is word aligned and wins over branch
  assert_jump_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |=> (pc[WORD_SHIFT-1:0] == '0) &&
                (pc[AW-HI_W-1:WORD_SHIFT] == $past(instr[IDX_W-1:0])) &&
                (pc[AW-1 -: HI_W] == $past(pc_plus4[AW-1 -: HI_W])));

  // R2: successor output tracks the register
  always_comb begin
    if (rst_n) begin
      assert_succ_step_R2: assert (pc_plus4 - pc == AW'(4));
    end
  end

endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic        is_branch;
  logic        is_jump;
  logic        alu_zero;
  logic [31:0] pc;
  logic [31:0] pc_plus4;

  int n_checks;
  int n_fail;
  int cycles;
  bit done;

  npc_unit i_npc_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr     (instr),
    .is_branch (is_branch),
    .is_jump   (is_jump),
    .alu_zero  (alu_zero),
    .pc        (pc),
    .pc_plus4  (pc_plus4)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam int NV = 11;
  // Control bits: {jump, branch, zero}
  localparam logic [2:0] V_CTL [0:NV-1] = '{
    3'b000, 3'b001, 3'b010, 3'b011, 3'b011, 3'b100,
    3'b111, 3'b000, 3'b100, 3'b011, 3'b011};
  localparam logic [31:0] V_INS [0:NV-1] = '{
    32'h0000_0000, 32'h0000_0010, 32'h0000_0010, 32'h0000_0010,
    32'h0000_FFFC, 32'h0812_3456, 32'h0BFF_FFFF, 32'h0000_0000,
    32'h0800_0010, 32'h0000_8000, 32'h0000_7FFF};
  localparam logic [31:0] V_EXP [0:NV-1] = '{
    32'h0000_0004,  // R3 fall through
    32'h0000_0008,  // R6 zero ignored without branch
    32'h0000_000C,  // R5 branch not taken
    32'h0000_0050,  // R4 forward branch
    32'h0000_0044,  // R10 backward branch
    32'h0048_D158,  // R7 jump in region 0
    32'h0FFF_FFFC,  // R8 jump beats taken branch
    32'h1000_0000,  // R3 fall through across region
    32'h1000_0040,  // R7 jump keeps region 1
    32'h0FFE_0044,  // R10 most negative offset
    32'h1000_0044}; // R4 most positive offset

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] ctl, input logic [31:0] ins);
    is_jump   = ctl[2];
    is_branch = ctl[1];
    alu_zero  = ctl[0];
    instr     = ins;
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b1;
    drive(3'b000, 32'h0);
    #1 rst_n = 1'b0;
    #2;
    check("R1 pc in reset", pc, 32'h0);
    check("R2 pc_plus4 in reset", pc_plus4, 32'h4);
    drive(3'b111, 32'h0BFF_FFFF);
    @(negedge clk);
    @(negedge clk);
    check("R1 reset held over edges", pc, 32'h0);
    drive(3'b000, 32'h0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      drive(V_CTL[k], V_INS[k]);
      @(negedge clk);
      check($sformatf("vector %0d pc (R3-tag table: see comments)", k), pc, V_EXP[k]);
      check("R2 pc_plus4 tracks pc", pc_plus4, V_EXP[k] + 32'd4);
    end

    // Asynchronous reset between edges
    #3 rst_n = 1'b0;
    #1;
    check("R1 async clear", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Wrap: 4 + (-8) lands at the top of the space
    drive(3'b011, 32'h0000_FFFE);
    @(negedge clk);
    check("R9 backward wrap pc", pc, 32'hFFFF_FFFC);
    check("R9 pc_plus4 wraps to 0", pc_plus4, 32'h0);
    drive(3'b000, 32'h0);
    @(negedge clk);
    check("R9 sequential wrap", pc, 32'h0);
    // Branch flag low with zero high at a new address
    drive(3'b001, 32'h0000_7FFF);
    @(negedge clk);
    check("R6 zero alone ignored", pc, 32'h4);

    done = 1'b1;
  end

  initial begin
    done   = 1'b0;
    cycles = 0;
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule